// File: doc/BRIEF.md
# Iterative Half-Adder Adder

This block adds two unsigned operands without a carry chain. Each bit position holds one half-adder whose inputs come through a two-way selector. On the first pass the selectors take the operand bits. On every later pass they take the sum the bit kept from the previous pass and the carry that the bit below passed up. One pass runs per clock. Passes repeat until no carry is left anywhere in the word, and then the block raises its completion flag.

A caller pulses `start` with the operands applied. It then waits for `done`, which stays high with a steady result until the next accepted start. The number of passes depends on the data. The block reports that number so that the surrounding logic can measure the latency the data actually needed.

Top module: `iha_adder`

## Requirements
- R1: While reset is held, and after it is released with no start, `done` is 0, `sum_out` is 0 and `iter_count` is 0.
- R2: A start that is accepted performs the first pass on that clock edge, with sum bit i = a[i] XOR b[i] and the carry into bit i+1 = a[i] AND b[i]. After that edge `iter_count` is 1. When a AND b is zero, `done` rises on the next edge with `sum_out` equal to a XOR b.
- R3: Each later pass sets sum bit i to its previous sum XOR the carry it received, and sets the carry into bit i+1 to their AND. When `done` is high, `sum_out` equals a+b as a WIDTH+1 bit value: bit WIDTH is the OR of every carry that left the top bit, and bits WIDTH-1..0 are the final sums.
- R4: `done` rises on the first edge at which all carries into bits 1..WIDTH are zero. If the addition needs N passes, `done` is 0 after start edges 0..N-1 and is 1 after edge N.
- R5: `done` is never asserted while the selectors pass operands. It is 0 in the cycle after any accepted start, including a restart from the finished state.
- R6: No bit ever holds carry-out = 1 together with sum = 1.
- R7: An addition takes at most WIDTH+1 passes. All ones plus one takes exactly WIDTH+1.
- R8: A start that arrives while passes are still running is ignored. The result and pass count belong to the first operands.
- R9: While `done` is high and no start arrives, `done`, `sum_out` and `iter_count` hold their values.
- R10: When `done` is high, `iter_count` equals the number of half-add passes performed, counting the first pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; accepted when no addition is running |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum_out | output | WIDTH+1 | Result: carry-out in the top bit, sums below |
| done | output | 1 | Completion flag, held until the next accepted start |
| iter_count | output | clog2(WIDTH+2) | Passes taken by the current or last addition |

## Verification
The bench builds the adder with WIDTH set to 6. At that width every one of the 4096 operand pairs can be run against a pass-by-pass reference, so every carry-run length from zero to the full word is covered, including the WIDTH+1 worst case. The done flag is compared on every cycle of every addition. Restarts from the finished state, start pulses injected during a run, and long holds after completion are mixed into the sweep.

// File: rtl/iha_pkg.sv
package iha_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } iha_state_e;

    typedef struct packed {
        logic s;
        logic c;
    } iha_pair_t;

    function automatic int iha_cnt_width(input int w);
        return $clog2(w + 2);
    endfunction

endpackage

// File: rtl/iha_cell.sv
module iha_cell
    import iha_pkg::*;
(
    input  logic      sel,
    input  logic      opa,
    input  logic      opb,
    input  logic      fb_sum,
    input  logic      fb_carry,
    output iha_pair_t res
);
    logic x;
    logic y;

    always_comb begin
        x     = sel ? fb_sum   : opa;
        y     = sel ? fb_carry : opb;
        res.s = x ^ y;
        res.c = x & y;
    end
endmodule

// File: rtl/iha_term_detect.sv
module iha_term_detect #(
    parameter int WIDTH = 32
) (
    input  logic           sel,
    input  logic [WIDTH:1] carries,
    output logic           term
);
    always_comb begin
        term = sel & ~(|carries);
    end
endmodule

// File: rtl/iha_ctrl.sv
module iha_ctrl
    import iha_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             term,
    output logic             sel,
    output logic             load,
    output logic             first,
    output logic             done,
    output logic [CNT_W-1:0] iter_count
);
    iha_state_e       state_q;
    iha_state_e       state_d;
    logic [CNT_W-1:0] iter_q;
    logic             accept;
    logic             step;

    always_comb begin
        accept  = start && (state_q != ST_RUN);
        step    = (state_q == ST_RUN) && !term;
        load    = accept || step;
        first   = accept;
        sel     = (state_q == ST_RUN);
        state_d = state_q;
        if (accept) begin
            state_d = ST_RUN;
        end else if ((state_q == ST_RUN) && term) begin
            state_d = ST_FIN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                iter_q <= CNT_W'(1);
            end else if (step) begin
                iter_q <= iter_q + 1'b1;
            end
        end
    end

    assign done       = (state_q == ST_FIN);
    assign iter_count = iter_q;
endmodule

// File: rtl/iha_adder.sv
module iha_adder
    import iha_pkg::*;
#(
    parameter  int WIDTH = 32,
    localparam int CNT_W = iha_pkg::iha_cnt_width(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH:0]   sum_out,
    output logic             done,
    output logic [CNT_W-1:0] iter_count
);
    logic [WIDTH-1:0] sum_q;
    logic [WIDTH:1]   carry_q;
    logic             cout_q;
    logic [WIDTH-1:0] next_sum;
    logic [WIDTH:1]   next_carry;
    logic             sel;
    logic             load;
    logic             first;
    logic             term;

    iha_pair_t cell_res [WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic cin;
        if (i == 0) begin : g_lsb
            assign cin = 1'b0;
        end else begin : g_upper
            assign cin = carry_q[i];
        end

        iha_cell u_cell (
            .sel      (sel),
            .opa      (op_a[i]),
            .opb      (op_b[i]),
            .fb_sum   (sum_q[i]),
            .fb_carry (cin),
            .res      (cell_res[i])
        );

        assign next_sum[i]     = cell_res[i].s;
        assign next_carry[i+1] = cell_res[i].c;
    end

    iha_term_detect #(.WIDTH(WIDTH)) u_term (
        .sel     (sel),
        .carries (carry_q),
        .term    (term)
    );

    iha_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .term       (term),
        .sel        (sel),
        .load       (load),
        .first      (first),
        .done       (done),
        .iter_count (iter_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            carry_q <= '0;
            cout_q  <= 1'b0;
        end else if (load) begin
            sum_q   <= next_sum;
            carry_q <= next_carry;
            cout_q  <= (cout_q & ~first) | next_carry[WIDTH];
        end
    end

    assign sum_out = {cout_q, sum_q};
endmodule

// File: rtl/iha_adder_chk.sv
module iha_adder_chk #(
    parameter  int WIDTH = 32,
    localparam int CNT_W = $clog2(WIDTH + 2)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic [WIDTH:0]   sum_out,
    input logic [CNT_W-1:0] iter_count,
    input logic             sel,
    input logic [WIDTH-1:0] sum_q,
    input logic [WIDTH:1]   carry_q
);
    // R6: a half-adder never leaves carry and sum both set
    assert_no_both_set_R6: assert property (@(posedge clk) disable iff (rst)
        (sum_q & carry_q) == '0);

    // R5: completion only follows a feedback phase
    assert_done_after_feedback_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(sel));

    // R4: all carries clear during feedback finishes the addition
    assert_finish_on_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (sel && (carry_q == '0)) |=> done);

    // R10: each pass with carries pending adds one to the count
    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        (sel && (carry_q != '0)) |=> (!done && (iter_count == CNT_W'($past(iter_count) + 1'b1))));

    // R8: a start during a run does not restart the count
    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (sel && start && (carry_q != '0)) |=> (iter_count == CNT_W'($past(iter_count) + 1'b1)));

    // R9: result held while finished and not restarted
    assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(sum_out) && $stable(iter_count)));

    // R7: pass count bounded
    assert_pass_bound_R7: assert property (@(posedge clk) disable iff (rst)
        iter_count <= CNT_W'(WIDTH + 1));
endmodule

bind iha_adder iha_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .done       (done),
    .sum_out    (sum_out),
    .iter_count (iter_count),
    .sel        (sel),
    .sum_q      (sum_q),
    .carry_q    (carry_q)
);

// File: tb/iha_adder_bench.sv
`timescale 1ns/1ps
module iha_adder_bench;
    localparam int W  = 6;
    localparam int CW = $clog2(W + 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [W:0]    sum_out;
    logic          done;
    logic [CW-1:0] iter_count;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    iha_adder #(.WIDTH(W)) u_iha_adder (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op_a       (op_a),
        .op_b       (op_b),
        .sum_out    (sum_out),
        .done       (done),
        .iter_count (iter_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pass-by-pass reference from the requirement formulas
    task automatic model(input int a, input int b, output int passes, output int res);
        int mask = (1 << W) - 1;
        int s    = (a ^ b) & mask;
        int c    = ((a & b) & mask) << 1;
        int cout = (c >> W) & 1;
        int cin;
        passes = 1;
        while (c != 0) begin
            cin    = c & mask & ~1;
            c      = (s & cin) << 1;
            s      = (s ^ cin) & mask;
            cout   = cout | ((c >> W) & 1);
            passes = passes + 1;
        end
        res = (cout << W) | s;
    endtask

    task automatic run_add(input int a, input int b, input bit poke, output int npass);
        int n;
        int r;
        model(a, b, n, r);
        npass = n;
        @(negedge clk);
        op_a  = W'(a);
        op_b  = W'(b);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R5 done low after start", int'(done), 0);
        if (poke) begin
            op_a  = ~W'(a);
            op_b  = W'(b + 1);
            start = 1'b1;
        end
        for (int k = 1; k <= n; k++) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            op_a  = W'(a);
            op_b  = W'(b);
            check(done == (k == n), "R4 done timing", int'(done), int'(k == n));
        end
        check(int'(sum_out) == a + b, "R3/R6 sum equals a+b", int'(sum_out), a + b);
        check(int'(sum_out) == r, "R3 sum matches pass model", int'(sum_out), r);
        check(int'(iter_count) == n, "R10 pass count", int'(iter_count), n);
        check(n <= W + 1, "R7 pass bound", n, W + 1);
        if (poke) begin
            check(int'(sum_out) == a + b, "R8 busy start ignored", int'(sum_out), a + b);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int n;
        int held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0 && sum_out == '0 && iter_count == '0, "R1 reset state",
              int'(sum_out), 0);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0 && sum_out == '0 && iter_count == '0, "R1 idle after reset",
              int'(done), 0);

        run_add(0, 0, 1'b0, n);
        check(n == 1, "R2 zero plus zero one pass", int'(iter_count), 1);
        run_add(6'b101010, 6'b010101, 1'b0, n);
        check(int'(sum_out) == 63 && n == 1, "R2 disjoint bits one pass", int'(sum_out), 63);
        run_add(63, 1, 1'b0, n);
        check(int'(iter_count) == W + 1, "R7 all ones plus one", int'(iter_count), W + 1);
        run_add(63, 63, 1'b1, n);

        held = int'(sum_out);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(done == 1'b1 && int'(sum_out) == held && int'(iter_count) == n,
              "R9 hold after done", int'(sum_out), held);

        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run_add(a, b, ((a + b) % 7) == 0, n);
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule